// File: doc/BRIEF.md
# UART Receive Character Queue

This block sits behind a serial receive front end. The front end takes care of bit sampling and baud timing, and it hands over each finished character with a strobe. Each character arrives with its data bits, its address-indicator (ninth) bit and its raw frame-error and parity-error status. The block keeps up to two unread characters in a small queue. Each queue entry carries that character's own error status, so the status a reader sees always belongs to the character at the head of the queue.

A third character can wait in a holding stage, which models the character left in the shift register. It enters the queue on the same clock edge that a read frees a slot. A read strobe pops the head. The block reports receive-complete, frame error, parity error and data overrun, and it drives a receive interrupt. When the address filter mode is enabled, frames without the address indicator are dropped before they reach the queue. Clearing the receiver enable empties everything.

Top module: `uart_rx_buffer`

## Requirements
- R1: After reset, `rx_complete`, `frame_err`, `parity_err`, `overrun` and `rx_irq` are 0 and `rd_data` is 0.
- R2: An accepted character is visible on `rd_data` one edge after its `char_done` cycle. Characters are read in arrival order. `rx_complete` is 1 while any unread character is held and 0 once the queue is empty.
- R3: `frame_err` equals the frame-error status that arrived with the character currently at the head, and it changes only when that character is popped.
- R4: `parity_err` is the head character's parity status. It is 1 only if `par_en` was 1 in the cycle that character arrived.
- R5: `char_bits` selects the character size: 0 for 5 bits, 1 for 6 bits, 2 for 7 bits, 3 for 8 bits. Data bits above the selected size read as 0.
- R6: A character that arrives while two are queued waits in the holding stage. It enters the queue on the edge of the next pop, so after that pop `rx_complete` stays 1.
- R7: `overrun` is set by a `start_det` pulse that comes while the queue is full, a character is waiting and no pop happens in the same cycle. It clears on the next edge at which a character is written into the queue.
- R8: With `mpc_mode` at 1, a character whose `char_addr` is 0 is discarded and never reaches the queue. Characters with `char_addr` at 1, and all characters when `mpc_mode` is 0, are accepted.
- R9: While `rx_en` is 0, the queue, the holding stage and `overrun` are cleared, and arriving characters are ignored.
- R10: A pop while the queue is empty has no effect.
- R11: `rx_irq` is 1 exactly when `rx_complete` and `rxc_ie` are both 1.
- R12: A character that arrives while the queue is full and another character is already waiting, with no pop in that cycle, is lost. The waiting character is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; 0 flushes all state |
| par_en | input | 1 | Parity checking enabled |
| mpc_mode | input | 1 | Address filter mode |
| char_bits | input | 2 | Character size code (0..3 = 5..8 bits) |
| rxc_ie | input | 1 | Receive interrupt enable |
| start_det | input | 1 | Start-bit detected strobe |
| char_done | input | 1 | Character assembled strobe |
| char_data | input | 8 | Assembled data bits |
| char_addr | input | 1 | Address-indicator bit of the character |
| char_ferr | input | 1 | First stop bit sampled as 0 |
| char_perr | input | 1 | Parity mismatch seen |
| rd_pop | input | 1 | Read strobe; pops the head |
| rd_data | output | 8 | Head character data, 0 when empty |
| rx_complete | output | 1 | Unread character present |
| frame_err | output | 1 | Head character frame error |
| parity_err | output | 1 | Head character parity error |
| overrun | output | 1 | Data overrun flag |
| rx_irq | output | 1 | Receive interrupt |

## Verification
Every result appears one edge after the cycle that holds the stimulus. A `char_done` shows up on `rd_data` and the flags after the next edge. A pop exposes the next entry, and admits the waiting character, on that same edge. A qualifying `start_det` raises `overrun` one edge later. The bench drives inputs and samples outputs on the falling clock edge, and each strobe is held for exactly one rising edge, so every comparison falls in the first cycle where the new value is due. A sweep of every data byte under every size code with varied error inputs covers masking and status carriage. Directed sequences cover the fill, wait, overrun, loss, filter and flush cases.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

    localparam int DATA_W   = 8;
    localparam int MIN_BITS = 5;

    typedef enum logic [1:0] {
        CHR_5 = 2'd0,
        CHR_6 = 2'd1,
        CHR_7 = 2'd2,
        CHR_8 = 2'd3
    } chr_size_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ferr;
        logic              perr;
    } rx_entry_t;

    function automatic logic [DATA_W-1:0] size_mask(input chr_size_e sz);
        logic [DATA_W-1:0] m;
        for (int i = 0; i < DATA_W; i++) begin
            m[i] = (i < (MIN_BITS + int'(sz)));
        end
        return m;
    endfunction

endpackage

// File: rtl/rxbuf_fifo.sv
module rxbuf_fifo
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      flush,
    input  logic      wr_en,
    input  rx_entry_t wr_entry,
    input  logic      pop_req,
    output rx_entry_t head,
    output logic      empty,
    output logic      full,
    output logic      pop_eff
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    rx_entry_t        slot_q [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CNT_W'(DEPTH));
    assign pop_eff = pop_req & ~empty;
    assign head    = slot_q[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) slot_q[s] <= '0;
        end else if (wr_en) begin
            for (int s = 0; s < DEPTH; s++) begin
                if (wr_ptr == PTR_W'(s)) slot_q[s] <= wr_entry;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_en)   wr_ptr <= ptr_inc(wr_ptr);
            if (pop_eff) rd_ptr <= ptr_inc(rd_ptr);
            case ({wr_en, pop_eff})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && !pop_req) |-> !wr_en);  // R6
    AST_POP_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (empty && !wr_en && !flush) |=> empty);  // R10

endmodule

// File: rtl/rxbuf_hold.sv
module rxbuf_hold
    import rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              mpc_mode,
    input  logic              par_en,
    input  logic [1:0]        char_bits,
    input  logic              start_det,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_addr,
    input  logic              char_ferr,
    input  logic              char_perr,
    input  logic              fifo_full,
    input  logic              pop_eff,
    output logic              wr_valid,
    output rx_entry_t         wr_entry,
    output logic              ovr
);

    rx_entry_t pend_q;
    logic      pend_v;
    rx_entry_t in_ent;
    logic      accept;
    logic      space;
    logic      ovr_hit;

    assign accept  = rx_en & char_done & (~mpc_mode | char_addr);
    assign space   = ~fifo_full | pop_eff;
    assign ovr_hit = start_det & pend_v & fifo_full & ~pop_eff;

    always_comb begin
        in_ent.data = char_data & size_mask(chr_size_e'(char_bits));
        in_ent.ferr = char_ferr;
        in_ent.perr = char_perr & par_en;
    end

    always_comb begin
        if (pend_v) begin
            wr_valid = rx_en & space;
            wr_entry = pend_q;
        end else begin
            wr_valid = accept & space;
            wr_entry = in_ent;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            pend_v <= 1'b0;
            pend_q <= '0;
            ovr    <= 1'b0;
        end else begin
            if (pend_v) begin
                if (space) begin
                    pend_v <= accept;
                    if (accept) pend_q <= in_ent;
                end
            end else if (accept && !space) begin
                pend_v <= 1'b1;
                pend_q <= in_ent;
            end
            if (ovr_hit)       ovr <= 1'b1;
            else if (wr_valid) ovr <= 1'b0;
        end
    end

    AST_OVR_SET: assert property (@(posedge clk) disable iff (rst)
        (rx_en && start_det && pend_v && fifo_full && !pop_eff) |=> ovr);  // R7
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (rx_en && wr_valid && !start_det) |=> !ovr);  // R7
    AST_ADDR_FILTER: assert property (@(posedge clk) disable iff (rst)
        (char_done && mpc_mode && !char_addr && !pend_v) |-> !wr_valid);  // R8
    AST_PARITY_GATE: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !pend_v && !par_en) |-> !wr_entry.perr);  // R4
    AST_SIZE_MASK: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !pend_v && char_bits == 2'd0) |-> (wr_entry.data[DATA_W-1:MIN_BITS] == '0));  // R5
    AST_LOST_KEEPS_WAITING: assert property (@(posedge clk) disable iff (rst)
        (rx_en && pend_v && !space) |=> (pend_v && pend_q == $past(pend_q)));  // R12

endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic              par_en,
    input  logic              mpc_mode,
    input  logic [1:0]        char_bits,
    input  logic              rxc_ie,
    input  logic              start_det,
    input  logic              char_done,
    input  logic [DATA_W-1:0] char_data,
    input  logic              char_addr,
    input  logic              char_ferr,
    input  logic              char_perr,
    input  logic              rd_pop,
    output logic [DATA_W-1:0] rd_data,
    output logic              rx_complete,
    output logic              frame_err,
    output logic              parity_err,
    output logic              overrun,
    output logic              rx_irq
);

    logic      wr_valid;
    rx_entry_t wr_entry;
    rx_entry_t head;
    logic      empty, full, pop_eff;
    logic      ovr;

    rxbuf_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .mpc_mode  (mpc_mode),
        .par_en    (par_en),
        .char_bits (char_bits),
        .start_det (start_det),
        .char_done (char_done),
        .char_data (char_data),
        .char_addr (char_addr),
        .char_ferr (char_ferr),
        .char_perr (char_perr),
        .fifo_full (full),
        .pop_eff   (pop_eff),
        .wr_valid  (wr_valid),
        .wr_entry  (wr_entry),
        .ovr       (ovr)
    );

    rxbuf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .flush    (~rx_en),
        .wr_en    (wr_valid),
        .wr_entry (wr_entry),
        .pop_req  (rd_pop),
        .head     (head),
        .empty    (empty),
        .full     (full),
        .pop_eff  (pop_eff)
    );

    assign rx_complete = ~empty;
    assign rd_data     = empty ? '0 : head.data;
    assign frame_err   = ~empty & head.ferr;
    assign parity_err  = ~empty & head.perr;
    assign overrun     = ovr;
    assign rx_irq      = rx_complete & rxc_ie;

    AST_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> (!rx_complete && !overrun));  // R9
    AST_HELD_UNTIL_READ: assert property (@(posedge clk) disable iff (rst)
        (rx_en && !rd_pop && rx_complete) |=> (rx_complete && $stable(rd_data) && $stable(frame_err)));  // R3

endmodule

// File: tb/uart_rx_buffer_tb_top.sv
module uart_rx_buffer_tb_top;

    logic       clk = 1'b0;
    logic       rst, rx_en, par_en, mpc_mode, rxc_ie;
    logic [1:0] char_bits;
    logic       start_det, char_done, char_addr, char_ferr, char_perr, rd_pop;
    logic [7:0] char_data;
    logic [7:0] rd_data;
    logic       rx_complete, frame_err, parity_err, overrun, rx_irq;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    uart_rx_buffer dut_i (
        .clk(clk), .rst(rst), .rx_en(rx_en), .par_en(par_en), .mpc_mode(mpc_mode),
        .char_bits(char_bits), .rxc_ie(rxc_ie), .start_det(start_det),
        .char_done(char_done), .char_data(char_data), .char_addr(char_addr),
        .char_ferr(char_ferr), .char_perr(char_perr), .rd_pop(rd_pop),
        .rd_data(rd_data), .rx_complete(rx_complete), .frame_err(frame_err),
        .parity_err(parity_err), .overrun(overrun), .rx_irq(rx_irq)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] d, input logic [1:0] sz, input logic fe, input logic pe, input logic ad);
        start_det = 1'b1;
        step();
        start_det = 1'b0;
        char_done = 1'b1; char_data = d; char_bits = sz;
        char_ferr = fe;   char_perr = pe; char_addr = ad;
        step();
        char_done = 1'b0;
    endtask

    task automatic pop();
        rd_pop = 1'b1;
        step();
        rd_pop = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; rx_en = 1'b1; par_en = 1'b0; mpc_mode = 1'b0; rxc_ie = 1'b0;
        char_bits = 2'd3; start_det = 1'b0; char_done = 1'b0; char_addr = 1'b0;
        char_ferr = 1'b0; char_perr = 1'b0; rd_pop = 1'b0; char_data = 8'h00;
        @(negedge clk);
        step(); step();
        rst = 1'b0;
        step();

        // R1 reset state
        chk("R1", "rx_complete", rx_complete, 0);
        chk("R1", "frame_err", frame_err, 0);
        chk("R1", "parity_err", parity_err, 0);
        chk("R1", "overrun", overrun, 0);
        chk("R1", "rx_irq", rx_irq, 0);
        chk("R1", "rd_data", rd_data, 0);

        // R5 R3 R4 sweep: every byte under every size code
        for (int sz = 0; sz < 4; sz++) begin
            for (int d = 0; d < 256; d++) begin
                logic [7:0] dv;
                logic fe, pe, pen;
                dv  = 8'(d);
                fe  = dv[0] ^ dv[5];
                pe  = dv[1];
                pen = dv[2];
                par_en = pen;
                send(dv, 2'(sz), fe, pe, 1'b0);
                chk("R2", "rx_complete after char", rx_complete, 1);
                chk("R5", "masked data", rd_data, 32'(d % (1 << (5 + sz))));
                chk("R3", "frame_err of head", frame_err, fe);
                chk("R4", "parity_err gated", parity_err, pe & pen);
                pop();
                chk("R2", "empty after pop", rx_complete, 0);
            end
        end
        par_en = 1'b0;

        // R2 R3 R4 ordering with per-character status
        par_en = 1'b1;
        send(8'hA1, 2'd3, 1'b1, 1'b0, 1'b0);
        send(8'hB2, 2'd3, 1'b0, 1'b1, 1'b0);
        chk("R2", "head is first", rd_data, 8'hA1);
        chk("R3", "first ferr", frame_err, 1);
        chk("R4", "first perr", parity_err, 0);
        pop();
        chk("R2", "second after pop", rd_data, 8'hB2);
        chk("R3", "second ferr", frame_err, 0);
        chk("R4", "second perr", parity_err, 1);
        pop();
        chk("R2", "empty after two pops", rx_complete, 0);
        par_en = 1'b0;

        // R7 full queue, no waiting character: start bit sets no overrun
        send(8'h11, 2'd3, 1'b0, 1'b0, 1'b0);
        send(8'h22, 2'd3, 1'b0, 1'b0, 1'b0);
        start_det = 1'b1; step(); start_det = 1'b0;
        chk("R7", "no overrun without waiting char", overrun, 0);
        // R6 third character waits
        send(8'h33, 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R6", "head unchanged while waiting", rd_data, 8'h11);
        chk("R7", "no overrun yet", overrun, 0);
        start_det = 1'b1; step(); start_det = 1'b0;
        chk("R7", "overrun set", overrun, 1);
        step();
        chk("R7", "overrun sticky", overrun, 1);
        pop();
        chk("R7", "overrun cleared by transfer", overrun, 0);
        chk("R6", "second at head", rd_data, 8'h22);
        chk("R6", "waiting moved in", rx_complete, 1);
        pop();
        chk("R6", "third at head", rd_data, 8'h33);
        pop();
        chk("R6", "empty after three", rx_complete, 0);

        // R12 fourth character lost
        send(8'h41, 2'd3, 1'b0, 1'b0, 1'b0);
        send(8'h42, 2'd3, 1'b0, 1'b0, 1'b0);
        send(8'h43, 2'd3, 1'b0, 1'b0, 1'b0);
        send(8'h44, 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R7", "overrun on fourth start", overrun, 1);
        pop();
        chk("R12", "second entry", rd_data, 8'h42);
        pop();
        chk("R12", "waiting char kept", rd_data, 8'h43);
        pop();
        chk("R12", "lost char absent", rx_complete, 0);

        // R8 address filter
        mpc_mode = 1'b1;
        send(8'h55, 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R8", "data frame dropped", rx_complete, 0);
        send(8'h66, 2'd3, 1'b0, 1'b0, 1'b1);
        chk("R8", "address frame kept", rd_data, 8'h66);
        pop();
        mpc_mode = 1'b0;
        send(8'h77, 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R8", "filter off keeps frame", rd_data, 8'h77);
        pop();

        // R10 pop when empty
        pop();
        chk("R10", "empty pop stays empty", rx_complete, 0);
        send(8'h88, 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R10", "next char intact", rd_data, 8'h88);
        // R11 interrupt
        chk("R11", "irq off when disabled", rx_irq, 0);
        rxc_ie = 1'b1; step();
        chk("R11", "irq on", rx_irq, 1);
        pop();
        chk("R11", "irq off when empty", rx_irq, 0);
        rxc_ie = 1'b0;

        // R9 flush
        send(8'h91, 2'd3, 1'b0, 1'b0, 1'b0);
        send(8'h92, 2'd3, 1'b0, 1'b0, 1'b0);
        send(8'h93, 2'd3, 1'b0, 1'b0, 1'b0);
        start_det = 1'b1; step(); start_det = 1'b0;
        rx_en = 1'b0; step();
        chk("R9", "flushed", rx_complete, 0);
        chk("R9", "overrun cleared", overrun, 0);
        send(8'h99, 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R9", "ignored while disabled", rx_complete, 0);
        rx_en = 1'b1; step();
        chk("R9", "waiting char flushed", rx_complete, 0);
        send(8'hAA, 2'd3, 1'b0, 1'b0, 1'b0);
        chk("R9", "works after enable", rd_data, 8'hAA);
        pop();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule